// File: doc/BRIEF.md
# Dual-Reload Down-Counting PWM Timer

This block is one timer channel that makes a pulse-width-modulated waveform with a down-counter. Two reload registers set the waveform. The low reload gives the number of input clock cycles the output stays low, minus one. The high reload does the same for the high level. A control register enables the timer. It also selects between reloading on terminal count (user mode) and wrapping freely, and between the two-register waveform and a symmetric square wave that uses only the low reload.

Software programs the timer through a simple write port. It reads the registers back through a read port whose data is registered. The intended order is to disable the timer, write the reloads and control bits, and then enable it again. Each enable starts a fresh low phase. The block also raises a one-cycle interrupt at every terminal count while it runs.

Top module: `pwm_dual_reload_timer`

## Requirements
- R1: After reset, every register reads as zero, and `pwm_out` and `irq` are low.
- R2: A write with `wr_en` high updates the register at `wr_addr`. The addresses are 0 for control, 1 for the low reload and 2 for the high reload. Address 3 ignores writes and reads as zero. In the control register, bit 0 enables, bit 1 selects user mode (1) and bit 3 selects the two-reload waveform (1). The other control bits read as zero. `rd_data` shows the register at `rd_addr` one clock edge after `rd_addr` is sampled.
- R3: The clock edge that writes the enable bit as 1 is called edge W. The following edge loads the counter from the low reload L, with the output low. `pwm_out` then rises at edge W+L+2, so the low phase lasts L+1 cycles.
- R4: In user mode with bit 3 set, each terminal count toggles `pwm_out`. A high phase lasts H+1 cycles, where H is the high reload. A low phase lasts L+1 cycles.
- R5: In user mode with bit 3 clear, both levels last L+1 cycles, and the high reload is ignored.
- R6: With bit 1 clear (free-running), the counter wraps from zero to all ones and `pwm_out` does not toggle. Successive terminal counts are therefore 2^CNT_W cycles apart.
- R7: `irq` is high for exactly one cycle at each terminal count. The pulse falls in the same cycle as the toggle it causes. `irq` never goes high while the timer is disabled.
- R8: Clearing the enable bit forces `pwm_out` low one edge later, with no interrupt, and freezes the counter. Enabling again reloads the counter from the low reload and starts a new low phase.
- R9: Writes to a reload register while the timer runs leave the phase in progress unchanged. The new value is used at the next reload that selects that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | CNT_W | Registered read data |
| pwm_out | output | 1 | PWM waveform, registered |
| irq | output | 1 | Terminal-count pulse, registered |

## Verification
The bench builds the timer with CNT_W set to 8. This shrinks the free-running wrap period to 256 cycles, so two consecutive free-running terminal counts fit in a short run and their spacing can be checked exactly. The reload values are kept small, so that several full waveform periods, a disable in the middle of a high phase, a re-enable with a changed low reload and a reload update in the middle of a phase can all be timed against edge counts worked out from the requirements.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_LOW  = 2'd1,
    REG_HIGH = 2'd2,
    REG_NONE = 2'd3
  } pwmt_reg_e;

  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_USER_BIT = 1;
  localparam int CTL_PWM_BIT  = 3;

  typedef struct packed {
    logic pwm;
    logic user;
    logic en;
  } pwmt_ctrl_t;

endpackage

// File: rtl/pwmt_regs.sv
module pwmt_regs
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output pwmt_ctrl_t       ctrl,
  output logic [CNT_W-1:0] low_rld,
  output logic [CNT_W-1:0] high_rld
);

  logic [CNT_W-1:0] ctrl_word;
  logic [CNT_W-1:0] rd_next;

  always_comb begin
    ctrl_word               = '0;
    ctrl_word[CTL_EN_BIT]   = ctrl.en;
    ctrl_word[CTL_USER_BIT] = ctrl.user;
    ctrl_word[CTL_PWM_BIT]  = ctrl.pwm;
  end

  always_comb begin
    case (pwmt_reg_e'(rd_addr))
      REG_CTRL: rd_next = ctrl_word;
      REG_LOW:  rd_next = low_rld;
      REG_HIGH: rd_next = high_rld;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      low_rld  <= '0;
      high_rld <= '0;
      rd_data  <= '0;
    end else begin
      rd_data <= rd_next;
      if (wr_en) begin
        case (pwmt_reg_e'(wr_addr))
          REG_CTRL: begin
            ctrl.en   <= wr_data[CTL_EN_BIT];
            ctrl.user <= wr_data[CTL_USER_BIT];
            ctrl.pwm  <= wr_data[CTL_PWM_BIT];
          end
          REG_LOW:  low_rld  <= wr_data;
          REG_HIGH: high_rld <= wr_data;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/pwmt_reload_sel.sv
module pwmt_reload_sel #(
  parameter int CNT_W = 32
) (
  input  logic             to_high,
  input  logic             pwm_mode,
  input  logic [CNT_W-1:0] low_rld,
  input  logic [CNT_W-1:0] high_rld,
  output logic [CNT_W-1:0] next_load
);

  // Two-reload waveform picks by next level; symmetric mode always uses low.
  always_comb begin
    if (pwm_mode && to_high) next_load = high_rld;
    else                     next_load = low_rld;
  end

endmodule

// File: rtl/pwmt_core.sv
module pwmt_core
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  pwmt_ctrl_t       ctrl,
  input  logic [CNT_W-1:0] low_rld,
  input  logic [CNT_W-1:0] high_rld,
  output logic             pwm_out,
  output logic             irq
);

  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [CNT_W-1:0] cnt;
  logic             en_q;
  logic             phase;
  logic [CNT_W-1:0] next_load;
  logic             at_tc;

  assign at_tc   = (cnt == CNT_ZERO);
  assign pwm_out = phase;

  pwmt_reload_sel #(.CNT_W(CNT_W)) u_sel (
    .to_high  (~phase),
    .pwm_mode (ctrl.pwm),
    .low_rld  (low_rld),
    .high_rld (high_rld),
    .next_load(next_load)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      en_q  <= 1'b0;
      phase <= 1'b0;
      irq   <= 1'b0;
    end else begin
      en_q <= ctrl.en;
      irq  <= 1'b0;
      if (!ctrl.en) begin
        phase <= 1'b0;
      end else if (!en_q) begin
        cnt   <= low_rld;
        phase <= 1'b0;
      end else if (at_tc) begin
        irq <= 1'b1;
        if (ctrl.user) begin
          phase <= ~phase;
          cnt   <= next_load;
        end else begin
          cnt <= CNT_MAX;
        end
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwm_dual_reload_timer.sv
module pwm_dual_reload_timer
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             pwm_out,
  output logic             irq
);

  pwmt_ctrl_t       ctrl;
  logic [CNT_W-1:0] low_rld;
  logic [CNT_W-1:0] high_rld;

  pwmt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .ctrl    (ctrl),
    .low_rld (low_rld),
    .high_rld(high_rld)
  );

  pwmt_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .ctrl    (ctrl),
    .low_rld (low_rld),
    .high_rld(high_rld),
    .pwm_out (pwm_out),
    .irq     (irq)
  );

endmodule

// File: rtl/pwmt_checker.sv
module pwmt_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             user,
  input logic [1:0]       rd_addr,
  input logic [CNT_W-1:0] rd_data,
  input logic             pwm_out,
  input logic             irq
);

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!pwm_out && !irq)); // R8

  AST_ENABLE_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(en) |-> !pwm_out); // R3

  AST_TOGGLE_AT_TC: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && $past(en, 2) && (pwm_out != $past(pwm_out))) |-> irq); // R7

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(en)); // R7

  AST_FREE_NO_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && !$past(user)) |-> $stable(pwm_out)); // R6

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_addr) == 2'd0) |-> (!rd_data[2] && ((rd_data >> 4) == '0))); // R2

endmodule

bind pwm_dual_reload_timer pwmt_checker #(.CNT_W(CNT_W)) u_pwmt_checker (
  .clk    (clk),
  .rst    (rst),
  .en     (ctrl.en),
  .user   (ctrl.user),
  .rd_addr(rd_addr),
  .rd_data(rd_data),
  .pwm_out(pwm_out),
  .irq    (irq)
);

// File: tb/test_pwm_dual_reload_timer.sv
module test_pwm_dual_reload_timer;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic [1:0]       rd_addr = '0;
  logic [CNT_W-1:0] rd_data;
  logic             pwm_out;
  logic             irq;

  pwm_dual_reload_timer #(.CNT_W(CNT_W)) i_pwm_dual_reload_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int    cyc;
    bit    lvl;
    bit    with_irq;
    string req;
  } edge_t;

  edge_t exp_q[$];
  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  int    irq_cnt = 0;
  int    irq_last = -1;
  int    irq_prev = -1;
  bit    done = 1'b0;
  bit    prev_pwm = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, int got, int exp, string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // Monitor: pops expected output edges as the design produces them.
  always @(negedge clk) begin
    if (!rst) begin
      if (pwm_out !== prev_pwm) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R4 unexpected toggle at cycle %0d: got level %0d expected none", cyc, pwm_out);
        end else begin
          edge_t e;
          e = exp_q.pop_front();
          chk(e.req, cyc, e.cyc, "toggle cycle");
          chk(e.req, int'(pwm_out), int'(e.lvl), "toggle level");
          chk("R7", int'(irq), int'(e.with_irq), "irq at toggle");
        end
      end
      prev_pwm = pwm_out;
      if (irq) begin
        irq_cnt++;
        irq_prev = irq_last;
        irq_last = cyc;
      end
    end
  end

  task automatic push(int c, bit l, bit i, string req);
    edge_t e;
    e.cyc = c; e.lvl = l; e.with_irq = i; e.req = req;
    exp_q.push_back(e);
  endtask

  // Called at a negedge; the write lands on the next posedge and the task
  // returns at the following negedge, where cyc equals that edge number.
  task automatic wr(logic [1:0] a, int d);
    wr_en = 1'b1; wr_addr = a; wr_data = CNT_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output int d);
    rd_addr = a;
    @(negedge clk);
    d = int'(rd_data);
  endtask

  task automatic wait_cyc(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int v;
    int w;
    int d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1", int'(pwm_out), 0, "pwm_out after reset");
    chk("R1", int'(irq), 0, "irq after reset");
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1", v, 0, "register after reset");
    end

    // R2 register access
    wr(2'd0, 'hF6);
    rd(2'd0, v); chk("R2", v, 'h02, "ctrl readback reserved bits zero");
    wr(2'd1, 'h5A);
    rd(2'd1, v); chk("R2", v, 'h5A, "low reload readback");
    wr(2'd2, 'hA5);
    rd(2'd2, v); chk("R2", v, 'hA5, "high reload readback");
    wr(2'd3, 'hFF);
    rd(2'd3, v); chk("R2", v, 0, "unused address reads zero");
    rd(2'd1, v); chk("R2", v, 'h5A, "low reload untouched by address 3");
    wr(2'd0, 0);

    // R3, R4, R7: two-reload waveform, L=3 H=5
    wr(2'd1, 3);
    wr(2'd2, 5);
    irq_cnt = 0;
    wr(2'd0, 'h0B); w = cyc;
    push(w + 5,  1, 1, "R3");
    push(w + 11, 0, 1, "R4");
    push(w + 15, 1, 1, "R4");
    push(w + 21, 0, 1, "R4");
    wait_cyc(w + 22);
    wr(2'd0, 'h0A);
    idle(20);
    chk("R7", irq_cnt, 4, "irq pulses in four phases");
    chk("R8", int'(pwm_out), 0, "output low while disabled");
    chk("R4", exp_q.size(), 0, "all expected toggles seen");

    // R8: disable in the high phase, then re-enable with new low reload
    irq_cnt = 0;
    wr(2'd0, 'h0B); w = cyc;
    push(w + 5, 1, 1, "R3");
    wait_cyc(w + 6);
    wr(2'd0, 'h0A); d = cyc;
    push(d + 1, 0, 0, "R8");
    idle(12);
    chk("R8", irq_cnt, 1, "no irq after disable");
    wr(2'd1, 6);
    irq_cnt = 0;
    wr(2'd0, 'h0B); w = cyc;
    push(w + 8, 1, 1, "R8");
    wait_cyc(w + 9);
    wr(2'd0, 'h0A); d = cyc;
    push(d + 1, 0, 0, "R8");
    idle(10);
    chk("R8", exp_q.size(), 0, "re-enable restarts low phase");
    chk("R8", irq_cnt, 1, "single irq before disable");

    // R5: symmetric mode, L=2, high reload ignored
    wr(2'd1, 2);
    irq_cnt = 0;
    wr(2'd0, 'h03); w = cyc;
    push(w + 4,  1, 1, "R5");
    push(w + 7,  0, 1, "R5");
    push(w + 10, 1, 1, "R5");
    push(w + 13, 0, 1, "R5");
    wait_cyc(w + 13);
    wr(2'd0, 'h02);
    idle(8);
    chk("R5", exp_q.size(), 0, "symmetric toggles seen");
    chk("R7", irq_cnt, 4, "irq per symmetric phase");

    // R9: reload writes during a running phase
    wr(2'd1, 3);
    wr(2'd2, 5);
    wr(2'd0, 'h0B); w = cyc;
    push(w + 5,  1, 1, "R9");
    push(w + 7,  0, 1, "R9");
    push(w + 17, 1, 1, "R9");
    wait_cyc(w + 2);
    wr(2'd2, 1);
    wr(2'd1, 9);
    wait_cyc(w + 17);
    wr(2'd0, 'h0A); d = cyc;
    push(d + 1, 0, 0, "R8");
    idle(6);
    chk("R9", exp_q.size(), 0, "updated reloads used at next reload");

    // R6: free-running wrap, L=2
    wr(2'd1, 2);
    irq_cnt = 0;
    wr(2'd0, 'h01); w = cyc;
    wait_cyc(w + 261);
    wr(2'd0, 0);
    idle(4);
    chk("R6", irq_cnt, 2, "free-running terminal counts");
    chk("R6", irq_prev, w + 4, "first free-running irq cycle");
    chk("R6", irq_last, w + 260, "wrap period");
    chk("R6", int'(pwm_out), 0, "no toggle in free-running mode");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule